// File: doc/BRIEF.md
# Double-Buffered Bridge PWM Generator

This block generates a pulse-width modulated signal from an 8-bit period timer. A prescaler divides the base clock by 1, 4 or 16. A 2-bit sub-count, taken from the prescaler, extends the timer so that the duty value has 10 bits of resolution. Software may write the duty value at any time, as an upper byte and a separate 2-bit low field. The value takes effect only when the current period ends, so every output period is built from one consistent duty value.

The modulated level is steered onto four drive outputs. Single mode drives only output A. Half-bridge mode drives a complementary pair, with a programmable dead time inserted at each edge. The two full-bridge modes, forward and reverse, hold one switch on and modulate the diagonal switch opposite it.

Top module: `pwm_bridge`

## Requirements
- R1: The 10-bit duty value is formed with `duty_hi_in` as bits 9..2 and `duty_lo_in` as bits 1..0. Each part is captured on its own write strobe, on any cycle.
- R2: The active (shadow) duty copy changes only on a period match. A duty write made during a period leaves that period's pulse width unchanged and takes effect in the following period.
- R3: The modulated level goes low when the timer joined with the 2-bit sub-count equals the shadow duty. With prescale factor N, a duty D that is below the period length gives a high time of D·N base clocks.
- R4: A duty value of 4·(period_in+1) or more never matches, so the modulated level stays high for the whole period.
- R5: A period lasts (period_in+1)·4·N base clocks. At the period match the timer returns to zero and the level is set high, except when the newly loaded duty is zero. In that case the level stays low.
- R6: `presc_sel` encoding: 0 selects N=1, 1 selects N=4, 2 and 3 select N=16.
- R7: `mode_sel` encoding: 0 single, 1 half-bridge, 2 full-bridge forward, 3 full-bridge reverse. In single mode only `out_a` carries the level, and `out_b`, `out_c` and `out_d` stay low.
- R8: In half-bridge mode `out_a` carries the level and `out_b` its complement. After every level change both are low for `dead_len` base clocks before the newly active one rises, and they are never high together.
- R9: In forward mode `out_a` is held high, `out_d` carries the level, and `out_b` and `out_c` are low. In reverse mode `out_c` is held high, `out_b` carries the level, and `out_a` and `out_d` are low.
- R10: After reset the level is low until the first period match, so in single mode all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_hi_we | input | 1 | Write strobe for the upper duty byte |
| duty_hi_in | input | TW | Upper duty bits |
| duty_lo_we | input | 1 | Write strobe for the 2-bit low duty field |
| duty_lo_in | input | 2 | Lower duty bits |
| period_in | input | TW | Period register, the last timer count of a period |
| presc_sel | input | 2 | Prescale select |
| mode_sel | input | 2 | Output steering mode |
| dead_len | input | DBW | Half-bridge dead time in base clocks |
| out_a | output | 1 | Drive output A |
| out_b | output | 1 | Drive output B |
| out_c | output | 1 | Drive output C |
| out_d | output | 1 | Drive output D |

## Verification
Some behaviours are checked by assertions on every cycle:
- the shadow duty holds its value on every cycle that is not a period match;
- the half-bridge pair never overlaps, and a dead gap precedes each rise of `out_a`;
- the fixed steering patterns of the single and full-bridge modes hold.

Other behaviours only the bench scenarios can show, because they are defined by counting cycles across whole periods:
- pulse and period lengths under each prescale factor;
- use of the low duty bits;
- the deferred effect of a mid-period write;
- the zero-duty and over-period boundaries;
- the exact dead-gap length.

// File: rtl/pwm_bridge.sv
module pwm_bridge #(
  parameter int TW  = 8,
  parameter int DBW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           duty_hi_we,
  input  logic [TW-1:0]  duty_hi_in,
  input  logic           duty_lo_we,
  input  logic [1:0]     duty_lo_in,
  input  logic [TW-1:0]  period_in,
  input  logic [1:0]     presc_sel,
  input  logic [1:0]     mode_sel,
  input  logic [DBW-1:0] dead_len,
  output logic           out_a,
  output logic           out_b,
  output logic           out_c,
  output logic           out_d
);
  localparam int DW = TW + 2;
  localparam int PW = 6;

  logic [TW-1:0]  duty_hi_q;
  logic [1:0]     duty_lo_q;
  logic [DW-1:0]  shadow_q;
  logic [TW-1:0]  tmr_q;
  logic [PW-1:0]  pre_q;
  logic           pwm_q;
  logic           lvl_q;
  logic [DBW-1:0] dead_q;

  logic           tick;
  logic [1:0]     sub;
  logic [DW-1:0]  pos;
  logic [DW-1:0]  next_duty;
  logic           match;
  logic           hit;
  logic           pwm_now;
  logic           dead_idle;

  always_comb begin
    case (presc_sel)
      2'd0:    begin tick = (pre_q[1:0] == 2'b11);   sub = pre_q[1:0]; end
      2'd1:    begin tick = (pre_q[3:0] == 4'hF);    sub = pre_q[3:2]; end
      default: begin tick = (pre_q == {PW{1'b1}});   sub = pre_q[5:4]; end
    endcase
  end

  assign pos       = {tmr_q, sub};
  assign next_duty = {duty_hi_q, duty_lo_q};
  assign match     = tick && (tmr_q == period_in);
  assign hit       = (pos == shadow_q);
  assign pwm_now   = pwm_q && !hit;
  assign dead_idle = (dead_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_hi_q <= '0;
      duty_lo_q <= '0;
    end else begin
      if (duty_hi_we) duty_hi_q <= duty_hi_in;
      if (duty_lo_we) duty_lo_q <= duty_lo_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      tmr_q    <= '0;
      shadow_q <= '0;
      pwm_q    <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) tmr_q <= match ? '0 : tmr_q + 1'b1;
      if (match) begin
        shadow_q <= next_duty;
        pwm_q    <= (next_duty != '0);
      end else if (hit) begin
        pwm_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      dead_q <= '0;
    end else begin
      lvl_q <= pwm_now;
      if (pwm_now != lvl_q)  dead_q <= dead_len;
      else if (!dead_idle)   dead_q <= dead_q - 1'b1;
    end
  end

  always_comb begin
    out_a = 1'b0;
    out_b = 1'b0;
    out_c = 1'b0;
    out_d = 1'b0;
    case (mode_sel)
      2'd0: out_a = lvl_q;
      2'd1: begin
        out_a = lvl_q && dead_idle;
        out_b = !lvl_q && dead_idle;
      end
      2'd2: begin
        out_a = 1'b1;
        out_d = lvl_q;
      end
      default: begin
        out_c = 1'b1;
        out_b = lvl_q;
      end
    endcase
  end

  p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(shadow_q));

  p_single_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd0) |-> !(out_b || out_c || out_d));

  p_half_nonoverlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd1) |-> !(out_a && out_b));

  p_half_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 2'd1) && $stable(mode_sel) && (dead_len != '0) && $rose(out_a))
      |-> !$past(out_b));

  p_fwd_steer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2) |-> (out_a && !out_b && !out_c));

  p_rev_steer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd3) |-> (out_c && !out_a && !out_d));

endmodule

// File: tb/tb_pwm_bridge.sv
`timescale 1ns/1ps
module tb_pwm_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       duty_hi_we = 1'b0;
  logic [7:0] duty_hi_in = '0;
  logic       duty_lo_we = 1'b0;
  logic [1:0] duty_lo_in = '0;
  logic [7:0] period_in = '0;
  logic [1:0] presc_sel = '0;
  logic [1:0] mode_sel = '0;
  logic [6:0] dead_len = '0;
  logic       out_a, out_b, out_c, out_d;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pwm_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .duty_hi_we(duty_hi_we), .duty_hi_in(duty_hi_in),
    .duty_lo_we(duty_lo_we), .duty_lo_in(duty_lo_in),
    .period_in(period_in), .presc_sel(presc_sel), .mode_sel(mode_sel),
    .dead_len(dead_len),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pin(input int i);
    case (i)
      0: return out_a;
      1: return out_b;
      2: return out_c;
      default: return out_d;
    endcase
  endfunction

  task automatic setcfg(input int p, input int dh, input int dl, input int ps,
                        input int md, input int db);
    @(negedge clk);
    period_in = 8'(p); duty_hi_in = 8'(dh); duty_lo_in = 2'(dl);
    duty_hi_we = 1'b1; duty_lo_we = 1'b1;
    presc_sel = 2'(ps); mode_sel = 2'(md); dead_len = 7'(db);
    @(negedge clk);
    duty_hi_we = 1'b0; duty_lo_we = 1'b0;
    repeat (500) @(negedge clk);
  endtask

  task automatic sync_rise(input int i);
    bit prev;
    prev = pin(i);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!prev && pin(i)) return;
      prev = pin(i);
    end
    chk("sync rise", 0, 1);
  endtask

  task automatic pulse(input int i, output int hi, output int per);
    bit in_low;
    int lo;
    hi = 1; lo = 0; in_low = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      duty_hi_we = 1'b0; duty_lo_we = 1'b0;
      if (!in_low) begin
        if (pin(i)) hi++;
        else begin in_low = 1; lo = 1; end
      end else begin
        if (pin(i)) break;
        lo++;
      end
    end
    per = hi + lo;
  endtask

  task automatic window(input int i, input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pin(i)) highs++;
    end
  endtask

  task automatic t_reset;
    int any;
    any = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (out_a || out_b || out_c || out_d) any++;
    end
    chk("R10 outputs low after reset", any, 0);
  endtask

  task automatic t_single;
    int hi, per, others;
    setcfg(9, 5, 0, 0, 0, 0);
    sync_rise(0);
    pulse(0, hi, per);
    chk("R3 high time D=20 N=1", hi, 20);
    chk("R5 period P=9 N=1", per, 40);
    window(1, 40, others);
    chk("R7 out_b idle in single", others, 0);
    window(3, 40, others);
    chk("R7 out_d idle in single", others, 0);
  endtask

  task automatic t_lowbits;
    int hi, per;
    setcfg(9, 5, 1, 0, 0, 0);
    sync_rise(0);
    pulse(0, hi, per);
    chk("R1 low duty bits D=21", hi, 21);
  endtask

  task automatic t_prescale;
    int hi, per;
    setcfg(4, 2, 2, 1, 0, 0);
    sync_rise(0);
    pulse(0, hi, per);
    chk("R6 high time N=4 D=10", hi, 40);
    chk("R6 period N=4 P=4", per, 80);
    setcfg(2, 1, 1, 2, 0, 0);
    sync_rise(0);
    pulse(0, hi, per);
    chk("R6 high time N=16 D=5", hi, 80);
    chk("R6 period N=16 P=2", per, 192);
  endtask

  task automatic t_buffer;
    int hi, per;
    setcfg(9, 5, 0, 0, 0, 0);
    sync_rise(0);
    duty_hi_in = 8'd2; duty_hi_we = 1'b1;
    pulse(0, hi, per);
    chk("R2 current period keeps old duty", hi, 20);
    pulse(0, hi, per);
    chk("R2 next period uses new duty", hi, 8);
  endtask

  task automatic t_bounds;
    int hi, per, highs;
    setcfg(9, 0, 0, 0, 0, 0);
    window(0, 80, highs);
    chk("R5 zero duty stays low", highs, 0);
    setcfg(9, 9, 3, 0, 0, 0);
    sync_rise(0);
    pulse(0, hi, per);
    chk("R3 duty 39 last position", hi, 39);
    chk("R3 duty 39 period", per, 40);
    setcfg(9, 10, 0, 0, 0, 0);
    window(0, 80, highs);
    chk("R4 duty 40 never cleared", highs, 80);
  endtask

  task automatic t_half;
    int hi, per, both_low, both_high;
    setcfg(9, 5, 0, 0, 1, 3);
    sync_rise(0);
    pulse(0, hi, per);
    chk("R8 out_a width with dead 3", hi, 17);
    chk("R8 out_a period", per, 40);
    sync_rise(1);
    pulse(1, hi, per);
    chk("R8 out_b width with dead 3", hi, 17);
    both_low = 0; both_high = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!out_a && !out_b) both_low++;
      if (out_a && out_b) both_high++;
    end
    chk("R8 dead cycles per period", both_low, 6);
    chk("R8 no overlap", both_high, 0);
    setcfg(9, 5, 0, 0, 1, 0);
    sync_rise(1);
    pulse(1, hi, per);
    chk("R8 out_b complement with no dead", hi, 20);
  endtask

  task automatic t_bridge;
    int hi, per, highs;
    setcfg(9, 5, 0, 0, 2, 0);
    window(0, 40, highs);
    chk("R9 forward out_a held", highs, 40);
    window(2, 40, highs);
    chk("R9 forward out_c off", highs, 0);
    sync_rise(3);
    pulse(3, hi, per);
    chk("R9 forward out_d width", hi, 20);
    setcfg(9, 5, 0, 0, 3, 0);
    window(2, 40, highs);
    chk("R9 reverse out_c held", highs, 40);
    window(3, 40, highs);
    chk("R9 reverse out_d off", highs, 0);
    sync_rise(1);
    pulse(1, hi, per);
    chk("R9 reverse out_b width", hi, 20);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_single;
    t_lowbits;
    t_prescale;
    t_buffer;
    t_bounds;
    t_half;
    t_bridge;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule